// File: doc/BRIEF.md
# Panel command bus bridge

This block connects a processor register port to an external parallel-bus display panel that takes commands and parameters over a narrow asynchronous-style bus. Software loads a 32-bit word into the write-data register; two flag bits in that word say whether it is a command (index) word or a parameter (data) word. A following write to the write-trigger register launches exactly one bus cycle to either the primary or the secondary panel. The bridge then reports busy until the cycle has finished.

Reads work the same way. Software first arms a read by writing the read-data register. It then writes the read-trigger register. When busy drops, the value sampled from the panel is in the low 18 bits of the read-data register. Every bus cycle has three phases: setup with chip select asserted, strobe pulse, and hold with chip select asserted. Each phase length comes from a timing register and is counted in system clocks.

Register word addresses: 0 write-data, 1 write-trigger, 2 read-data, 3 read-trigger, 4 status, 5 timing.

Top module: `pbus_bridge`

## Requirements
- R1: After reset, both chip selects (`pnl_cs_n`) read 1 and both strobes read 1. The status register (address 4) reads 0. The read-data register (address 2) reads 0.
- R2: Write-data (address 0) holds a word with bit 28 = 1 and bit 24 = 0. Writing 1 to bit 0 of write-trigger (address 1) then runs one write cycle. In that cycle `pnl_rs` = 0, `pnl_wr_n` pulses low, `pnl_rd_n` stays high, `pnl_oe` = 1 and `pnl_dout` = word[17:0].
- R3: A word with both bit 28 and bit 24 set runs the same kind of write cycle with `pnl_rs` = 1. `pnl_rs` does not change during a cycle.
- R4: A write to write-trigger with bit 0 = 0 starts no cycle. A write-data word with bit 28 = 0 starts no cycle either, even with a trigger bit 0 = 1. Neither case sets the error bit.
- R5: Bit 1 of the write-trigger or read-trigger word picks the panel. 0 drives `pnl_cs_n[0]` low and 1 drives `pnl_cs_n[1]` low. The chosen select stays low for the whole cycle, and the other select stays high.
- R6: Status bit 1 (busy) reads 1 from the clock after an accepted trigger up to the last clock of the cycle. It reads 0 afterwards. While busy is 0, no chip select and no strobe is active.
- R7: Writing read-data (address 2) with bit 24 = 1 arms a read. Bit 0 = 1 in read-trigger (address 3) then runs one read cycle. In that cycle `pnl_rd_n` pulses low, `pnl_wr_n` stays high, `pnl_rs` = 1 and `pnl_oe` = 0. A read trigger with no read armed starts no cycle.
- R8: After a read cycle, read-data bits 17:0 hold `pnl_din` as sampled on the last clock of the strobe pulse. Bits 31:18 read 0.
- R9: The timing register (address 5) sets three phase lengths in clocks: setup in bits 7:0, strobe pulse in bits 15:8 and hold in bits 23:16. A field of 0 counts as 1, so a cycle always takes at least 3 clocks. The reset values are 1, 2 and 1.
- R10: A trigger (bit 0 = 1) written while busy is 1 starts nothing and changes nothing in the running cycle. It sets status bit 0 (sticky error). This includes a trigger on the last clock of a cycle. Writing status with bit 0 = 1 clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| pnl_cs_n | output | 2 | Active-low panel selects, bit 0 primary, bit 1 secondary |
| pnl_rs | output | 1 | Register select: 0 index, 1 data |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_dout | output | 18 | Data driven to the panel during write cycles |
| pnl_oe | output | 1 | Output enable for `pnl_dout` |
| pnl_din | input | 18 | Data returned by the panel |

## Verification
Two events can meet in the same clock: a new trigger arriving and the end of the running cycle on its last hold clock. The bench provokes this by counting clocks from a trigger under known short timing. It then issues the second trigger so that it is sampled at the edge that ends the cycle. The expected result is that the second trigger is rejected and busy falls. The error bit must be set, and no new chip select may appear in the clocks that follow. A second case places a trigger one clock into a cycle. There the running cycle must finish with its full programmed length.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_WDATA = 3'd0,
    A_WTRIG = 3'd1,
    A_RDATA = 3'd2,
    A_RTRIG = 3'd3,
    A_STAT  = 3'd4,
    A_TIME  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } phase_e;

  localparam int BIT_CMD  = 28;
  localparam int BIT_DAT  = 24;
  localparam int BIT_GO   = 0;
  localparam int BIT_SEL  = 1;
  localparam int BIT_BUSY = 1;
  localparam int BIT_ERR  = 0;

  // A zero-length phase still takes one clock.
  function automatic int unsigned phase_len(input int unsigned field);
    return (field == 0) ? 1 : field;
  endfunction

  // Counter preload for a phase of the given programmed length.
  function automatic int unsigned phase_load(input int unsigned field);
    return phase_len(field) - 1;
  endfunction
endpackage

// File: rtl/pbb_regs.sv
module pbb_regs
  import pbb_pkg::*;
#(
  parameter int DW = 18,
  parameter int TW = 8,
  parameter logic [TW-1:0] RST_SETUP = 1,
  parameter logic [TW-1:0] RST_PULSE = 2,
  parameter logic [TW-1:0] RST_HOLD  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DW-1:0]     rd_value,
  output logic              go,
  output logic              go_read,
  output logic              go_sub,
  output logic              go_rs,
  output logic [DW-1:0]     go_word,
  output logic [TW-1:0]     t_setup,
  output logic [TW-1:0]     t_pulse,
  output logic [TW-1:0]     t_hold,
  output logic              reject,
  output logic              err
);
  logic [REG_W-1:0] wword_q;
  logic [DW-1:0]    rd_q;
  logic             armed_q;
  logic             hit_wdata, hit_wtrig, hit_rdata, hit_rtrig, hit_stat, hit_time;
  logic             trig_w, trig_r, acc_w, acc_r;

  always_comb begin
    hit_wdata = we && (addr == A_WDATA);
    hit_wtrig = we && (addr == A_WTRIG);
    hit_rdata = we && (addr == A_RDATA);
    hit_rtrig = we && (addr == A_RTRIG);
    hit_stat  = we && (addr == A_STAT);
    hit_time  = we && (addr == A_TIME);
    trig_w    = hit_wtrig && wdata[BIT_GO];
    trig_r    = hit_rtrig && wdata[BIT_GO];
    reject    = (trig_w || trig_r) && busy;
    acc_w     = trig_w && !busy && wword_q[BIT_CMD];
    acc_r     = trig_r && !busy && armed_q;
    go        = acc_w || acc_r;
    go_read   = acc_r;
    go_sub    = wdata[BIT_SEL];
    go_rs     = acc_r || wword_q[BIT_DAT];
    go_word   = wword_q[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wword_q <= '0;
      rd_q    <= '0;
      armed_q <= 1'b0;
      err     <= 1'b0;
      t_setup <= RST_SETUP;
      t_pulse <= RST_PULSE;
      t_hold  <= RST_HOLD;
    end else begin
      if (hit_wdata) wword_q <= wdata;
      if (hit_time) begin
        t_setup <= wdata[TW-1:0];
        t_pulse <= wdata[2*TW-1:TW];
        t_hold  <= wdata[3*TW-1:2*TW];
      end
      if (hit_rdata)    armed_q <= wdata[BIT_DAT];
      else if (rd_done) armed_q <= 1'b0;
      if (rd_done) rd_q <= rd_value;
      // A rejected trigger wins over a clear in the same cycle.
      if (reject)                          err <= 1'b1;
      else if (hit_stat && wdata[BIT_ERR]) err <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_WDATA: rdata = wword_q;
      A_RDATA: rdata = REG_W'(rd_q);
      A_STAT: begin
        rdata[BIT_BUSY] = busy;
        rdata[BIT_ERR]  = err;
      end
      A_TIME:  rdata = REG_W'({t_hold, t_pulse, t_setup});
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbb_seq.sv
module pbb_seq
  import pbb_pkg::*;
#(
  parameter int DW     = 18,
  parameter int TW     = 8,
  parameter int NPANEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_read,
  input  logic              go_sub,
  input  logic              go_rs,
  input  logic [DW-1:0]     go_word,
  input  logic [TW-1:0]     t_setup,
  input  logic [TW-1:0]     t_pulse,
  input  logic [TW-1:0]     t_hold,
  input  logic [DW-1:0]     bus_din,
  output logic              busy,
  output logic              rd_done,
  output logic [DW-1:0]     rd_value,
  output logic [NPANEL-1:0] cs_n,
  output logic              rs,
  output logic              wr_n,
  output logic              rd_n,
  output logic [DW-1:0]     dout,
  output logic              oe
);
  localparam int SW = (NPANEL > 1) ? $clog2(NPANEL) : 1;

  phase_e          ph_q;
  logic [TW-1:0]   cnt_q, tp_q, th_q;
  logic [SW-1:0]   sel_q;
  logic            read_q, last;
  logic [DW-1:0]   word_q, cap_q;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      tp_q   <= '0;
      th_q   <= '0;
      sel_q  <= '0;
      rs     <= 1'b0;
      read_q <= 1'b0;
      word_q <= '0;
      cap_q  <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go) begin
          ph_q   <= PH_SETUP;
          cnt_q  <= TW'(phase_load(32'(t_setup)));
          tp_q   <= t_pulse;
          th_q   <= t_hold;
          sel_q  <= SW'(go_sub);
          rs     <= go_rs;
          read_q <= go_read;
          word_q <= go_word;
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_PULSE;
          cnt_q <= TW'(phase_load(32'(tp_q)));
        end else cnt_q <= cnt_q - 1'b1;
        PH_PULSE: if (last) begin
          ph_q  <= PH_HOLD;
          cnt_q <= TW'(phase_load(32'(th_q)));
          if (read_q) cap_q <= bus_din;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (last) ph_q <= PH_IDLE;
                 else      cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (ph_q != PH_IDLE);
  assign rd_done  = (ph_q == PH_HOLD) && last && read_q;
  assign rd_value = cap_q;
  assign wr_n     = !((ph_q == PH_PULSE) && !read_q);
  assign rd_n     = !((ph_q == PH_PULSE) && read_q);
  assign oe       = busy && !read_q;
  assign dout     = oe ? word_q : '0;

  for (genvar i = 0; i < NPANEL; i++) begin : g_cs
    assign cs_n[i] = !(busy && (sel_q == SW'(i)));
  end
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbb_pkg::*;
#(
  parameter int DW = 18,
  parameter int TW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [1:0]        pnl_cs_n,
  output logic              pnl_rs,
  output logic              pnl_wr_n,
  output logic              pnl_rd_n,
  output logic [DW-1:0]     pnl_dout,
  output logic              pnl_oe,
  input  logic [DW-1:0]     pnl_din
);
  logic          busy_w, rd_done_w, go_w, go_read_w, go_sub_w, go_rs_w;
  logic          reject_w, err_w;
  logic [DW-1:0] go_word_w, rd_value_w;
  logic [TW-1:0] t_setup_w, t_pulse_w, t_hold_w;

  pbb_regs #(.DW(DW), .TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_w),
    .rd_done(rd_done_w), .rd_value(rd_value_w), .go(go_w),
    .go_read(go_read_w), .go_sub(go_sub_w), .go_rs(go_rs_w),
    .go_word(go_word_w), .t_setup(t_setup_w), .t_pulse(t_pulse_w),
    .t_hold(t_hold_w), .reject(reject_w), .err(err_w)
  );

  pbb_seq #(.DW(DW), .TW(TW), .NPANEL(2)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .go_read(go_read_w),
    .go_sub(go_sub_w), .go_rs(go_rs_w), .go_word(go_word_w),
    .t_setup(t_setup_w), .t_pulse(t_pulse_w), .t_hold(t_hold_w),
    .bus_din(pnl_din), .busy(busy_w), .rd_done(rd_done_w),
    .rd_value(rd_value_w), .cs_n(pnl_cs_n), .rs(pnl_rs),
    .wr_n(pnl_wr_n), .rd_n(pnl_rd_n), .dout(pnl_dout), .oe(pnl_oe)
  );
endmodule

// File: rtl/pbb_checker.sv
module pbb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       go,
  input logic       reject,
  input logic       err,
  input logic       rd_done,
  input logic [1:0] cs_n,
  input logic       rs,
  input logic       wr_n,
  input logic       rd_n
);
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == 2'b11) && wr_n && rd_n);

  assert_one_panel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_strobe_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> (cs_n != 2'b11));

  assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> rd_n);

  assert_start_from_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  assert_rs_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rs));

  assert_reject_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err);

  assert_read_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !busy);
endmodule

bind pbus_bridge pbb_checker u_pbb_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .go(go_w), .reject(reject_w),
  .err(err_w), .rd_done(rd_done_w), .cs_n(pnl_cs_n), .rs(pnl_rs),
  .wr_n(pnl_wr_n), .rd_n(pnl_rd_n)
);

// File: tb/test_pbus_bridge.sv
`timescale 1ns/1ps
module test_pbus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pnl_cs_n;
  logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_oe;
  logic [17:0] pnl_dout;
  logic [17:0] pnl_din = '0;

  int tests = 0;
  int fails = 0;

  localparam logic [2:0] AW_DATA = 3'd0, AW_TRIG = 3'd1, AR_DATA = 3'd2,
                         AR_TRIG = 3'd3, A_STATUS = 3'd4, A_TIMING = 3'd5;

  always #4 clk = ~clk;

  pbus_bridge i_pbus_bridge (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pnl_cs_n(pnl_cs_n),
    .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
    .pnl_dout(pnl_dout), .pnl_oe(pnl_oe), .pnl_din(pnl_din)
  );

  // Expected cycle shape, written from the requirement text.
  function automatic int eff(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; the write lands at the next posedge.
  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Samples each clock while busy; tracks phase lengths and bus levels.
  task automatic measure(input logic [17:0] din_base,
                         output int s, output int p, output int h,
                         output logic [1:0] cs, output logic rs_v,
                         output int wr_low, output int rd_low,
                         output logic [17:0] dseen, output int oe_cnt);
    int n = 0;
    s = 0; p = 0; h = 0; wr_low = 0; rd_low = 0; oe_cnt = 0;
    cs = 2'b11; rs_v = 1'b0; dseen = '0;
    while (pnl_cs_n != 2'b11 && n < 1000) begin
      cs = pnl_cs_n; rs_v = pnl_rs;
      if (pnl_oe) oe_cnt++;
      if (!pnl_wr_n) begin wr_low++; dseen = pnl_dout; end
      if (!pnl_rd_n) rd_low++;
      if (!pnl_wr_n || !pnl_rd_n) begin
        p++;
        pnl_din = din_base + 18'(p);
      end else if (p == 0) s++;
      else h++;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, output int active);
    active = 0;
    for (int i = 0; i < n; i++) begin
      if (pnl_cs_n != 2'b11 || !pnl_wr_n || !pnl_rd_n) active++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(pnl_cs_n == 2'b11, "R1", "cs_n", pnl_cs_n, 2'b11);
    chk(pnl_wr_n && pnl_rd_n, "R1", "strobes", {pnl_wr_n, pnl_rd_n}, 2'b11);
    rreg(A_STATUS, v);
    chk(v == 0, "R1", "status", v, 0);
    rreg(AR_DATA, v);
    chk(v == 0, "R1", "read data", v, 0);
  endtask

  task automatic t_index_write;
    logic [31:0] v; int s, p, h, wl, rl, oc; logic [1:0] cs; logic rsv; logic [17:0] d;
    wreg(AW_DATA, 32'h1000_0000 | 32'h1_2345);
    wreg(AW_TRIG, 32'h1);
    rreg(A_STATUS, v);
    chk(v[1] == 1'b1, "R6", "busy during cycle", v[1], 1);
    measure(18'h0, s, p, h, cs, rsv, wl, rl, d, oc);
    chk(rsv == 1'b0, "R2", "rs index", rsv, 0);
    chk(cs == 2'b10, "R5", "primary cs", cs, 2'b10);
    chk(wl == 2 && rl == 0, "R2", "wr pulse clocks", wl, 2);
    chk(d == 18'h1_2345, "R2", "dout", d, 18'h1_2345);
    chk(oc == s + p + h, "R2", "oe whole cycle", oc, s + p + h);
    chk(s == 1 && h == 1, "R9", "reset setup/hold", {s, h}, {32'd1, 32'd1});
    rreg(A_STATUS, v);
    chk(v[1] == 1'b0, "R6", "busy after cycle", v[1], 0);
  endtask

  task automatic t_data_write_sub;
    int s, p, h, wl, rl, oc; logic [1:0] cs; logic rsv; logic [17:0] d;
    wreg(AW_DATA, 32'h1100_0000 | 32'h3_ABCD);
    wreg(AW_TRIG, 32'h3);
    measure(18'h0, s, p, h, cs, rsv, wl, rl, d, oc);
    chk(rsv == 1'b1, "R3", "rs data", rsv, 1);
    chk(cs == 2'b01, "R5", "secondary cs", cs, 2'b01);
    chk(d == 18'h3_ABCD, "R3", "dout", d, 18'h3_ABCD);
  endtask

  task automatic t_no_go;
    int act; logic [31:0] v;
    wreg(AW_DATA, 32'h1000_0055);
    wreg(AW_TRIG, 32'h2);
    quiet(6, act);
    chk(act == 0, "R4", "trigger bit0 clear", act, 0);
    wreg(AW_DATA, 32'h0100_0055);
    wreg(AW_TRIG, 32'h1);
    quiet(6, act);
    chk(act == 0, "R4", "word without bit28", act, 0);
    rreg(A_STATUS, v);
    chk(v == 0, "R4", "no error flagged", v, 0);
  endtask

  task automatic t_timing;
    int s, p, h, wl, rl, oc; logic [1:0] cs; logic rsv; logic [17:0] d;
    wreg(A_TIMING, {8'd0, 8'd3, 8'd4, 8'd2});
    wreg(AW_DATA, 32'h1000_0001);
    wreg(AW_TRIG, 32'h1);
    measure(18'h0, s, p, h, cs, rsv, wl, rl, d, oc);
    chk(s == eff(2) && p == eff(4) && h == eff(3), "R9", "2/4/3 phases",
        {s[7:0], p[7:0], h[7:0]}, 24'h020403);
    wreg(A_TIMING, 32'h0);
    wreg(AW_TRIG, 32'h1);
    measure(18'h0, s, p, h, cs, rsv, wl, rl, d, oc);
    chk(s == 1 && p == 1 && h == 1, "R9", "zero fields",
        {s[7:0], p[7:0], h[7:0]}, 24'h010101);
    wreg(A_TIMING, {8'd0, 8'd1, 8'd2, 8'd1});
  endtask

  task automatic t_read;
    int s, p, h, wl, rl, oc, act; logic [1:0] cs; logic rsv; logic [17:0] d;
    logic [31:0] v;
    wreg(AR_TRIG, 32'h1);
    quiet(6, act);
    chk(act == 0, "R7", "unarmed read", act, 0);
    wreg(AR_DATA, 32'h0100_0000);
    wreg(AR_TRIG, 32'h3);
    measure(18'h2_F000, s, p, h, cs, rsv, wl, rl, d, oc);
    chk(rl == 2 && wl == 0, "R7", "rd pulse only", {rl[7:0], wl[7:0]}, 16'h0200);
    chk(rsv == 1'b1 && oc == 0, "R7", "rs high, no drive", {rsv, oc[7:0]}, 9'h100);
    chk(cs == 2'b01, "R5", "read to secondary", cs, 2'b01);
    rreg(AR_DATA, v);
    chk(v == 32'(18'h2_F000 + 18'd2), "R8", "read value", v, 32'(18'h2_F002));
    wreg(AR_TRIG, 32'h1);
    quiet(6, act);
    chk(act == 0, "R7", "arm consumed", act, 0);
  endtask

  task automatic t_reject;
    int n, act; logic [31:0] v;
    wreg(AW_DATA, 32'h1000_0007);
    wreg(AW_TRIG, 32'h1);
    wreg(AW_TRIG, 32'h3);
    n = 0;
    while (pnl_cs_n != 2'b11 && n < 100) begin
      chk(pnl_cs_n == 2'b10, "R10", "running cycle kept", pnl_cs_n, 2'b10);
      n++;
      @(negedge clk);
    end
    chk(n == 3, "R10", "remaining clocks", n, 3);
    quiet(5, act);
    chk(act == 0, "R10", "no restart", act, 0);
    rreg(A_STATUS, v);
    chk(v[0] == 1'b1, "R10", "error set", v[0], 1);
    wreg(A_STATUS, 32'h1);
    rreg(A_STATUS, v);
    chk(v[0] == 1'b0, "R10", "error cleared", v[0], 0);
    // Trigger sampled at the edge that ends the cycle.
    wreg(A_TIMING, {8'd0, 8'd2, 8'd1, 8'd1});
    wreg(AW_TRIG, 32'h1);
    repeat (3) @(negedge clk);
    wreg(AW_TRIG, 32'h1);
    chk(pnl_cs_n == 2'b11, "R10", "ends on last hold", pnl_cs_n, 2'b11);
    quiet(5, act);
    chk(act == 0, "R10", "edge trigger ignored", act, 0);
    rreg(A_STATUS, v);
    chk(v == 32'h1, "R10", "status after collision", v, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index_write();
    t_data_write_sub();
    t_no_go();
    t_timing();
    t_read();
    t_reject();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule